// File: doc/BRIEF.md
# Status LED Blink Frame Generator

This block drives one status LED with a repeating frame of eight equal time slots. It shows the board controller's condition as the number of lit slots at the start of each frame. Three status flags come in: one says a reset request is being held, one says the boot mode was changed by software, and one says the bank-voltage strap pin was changed. A prescaler sets the slot length. A 3-bit slot counter walks through the frame.

The displayed pattern is a state machine with five named states:

- `PAT_OFF`: no slot lit.
- `PAT_BANK`: 3 slots lit.
- `PAT_BOOT`: 4 slots lit.
- `PAT_BOTH`: 5 slots lit.
- `PAT_ALL`: 8 slots lit.

There is one transition, `FRAME_WRAP`. It fires on the prescaler tick that moves the slot counter from slot 7 to slot 0. On that transition the machine re-selects its state from the current flags by priority. In every other cycle it holds its state (`HOLD`), so a frame that has started always runs to its end.

Synchronous reset forces `PAT_OFF`, slot 0, a cleared prescaler and a dark LED. The first frame after reset is therefore always dark. With the default prescaler width and a 24.18 MHz clock, one slot lasts about 87 ms and one frame about 0.7 s.

Top module: `led_frame_blinker`

## Requirements
- R1: A synchronous reset clears the prescaler, the slot counter and the pattern state to `PAT_OFF`, and drives `led_o` low from the first clock edge at which `rst` is sampled high.
- R2: Each slot lasts exactly 2^PRESCALE_W clock cycles, and a frame is 8 slots. Counting rising edges since reset released as e, the slot shown is (e / 2^PRESCALE_W) mod 8.
- R3: When `rst_active_i` is high at a frame wrap, all 8 slots of the next frame are lit.
- R4: When `boot_chg_i` and `bank_chg_i` are both high at a frame wrap (and `rst_active_i` is low), slots 0 to 4 are lit and slots 5 to 7 are dark.
- R5: When only `boot_chg_i` is high at a frame wrap, slots 0 to 3 are lit and slots 4 to 7 are dark.
- R6: When only `bank_chg_i` is high at a frame wrap, slots 0 to 2 are lit and slots 3 to 7 are dark.
- R7: When no flag is high at a frame wrap, the whole next frame is dark.
- R8: Priority from highest to lowest: `rst_active_i`, then both change flags, then `boot_chg_i` alone, then `bank_chg_i` alone, then off.
- R9: The pattern is selected only at the frame wrap (slot 7 to slot 0). A flag change in mid-frame has no effect on the frame in progress, and the first frame after reset is dark whatever the flags are.
- R10: `led_o` is active high and registered. It changes only on a slot boundary, and the lit slots always come first in the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_active_i | input | 1 | Reset request is being held |
| boot_chg_i | input | 1 | Boot mode changed by software |
| bank_chg_i | input | 1 | Bank-voltage strap pin changed |
| led_o | output | 1 | LED drive, active high |

## Verification
The hardest case to reach from the ports is a flag change that lands inside a running frame. It must leave the rest of that frame unchanged and take effect exactly one frame later. The bench reaches it by building the prescaler small and tracking its own count of edges since reset, which puts it at a known slot. It then raises a higher-priority flag in slot 2 of a boot-only frame and compares every cycle of that frame and the next. The same edge count lets it check every cycle of a frame, including the exact cycle of each slot boundary.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    localparam int SLOT_W      = 3;
    localparam int SLOTS       = 1 << SLOT_W;
    localparam int LIT_W       = SLOT_W + 1;

    typedef enum logic [2:0] {
        PAT_OFF  = 3'd0,
        PAT_BANK = 3'd1,
        PAT_BOOT = 3'd2,
        PAT_BOTH = 3'd3,
        PAT_ALL  = 3'd4
    } pat_e;

    function automatic logic [LIT_W-1:0] lit_slots(input pat_e p);
        logic [LIT_W-1:0] n;
        unique case (p)
            PAT_OFF:  n = LIT_W'(0);
            PAT_BANK: n = LIT_W'(3);
            PAT_BOOT: n = LIT_W'(4);
            PAT_BOTH: n = LIT_W'(5);
            PAT_ALL:  n = LIT_W'(SLOTS);
            default:  n = LIT_W'(0);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
    parameter int PRESCALE_W = 21
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam logic [PRESCALE_W-1:0] LAST = {PRESCALE_W{1'b1}};

    logic [PRESCALE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o || (PRESCALE_W == 0));

endmodule

// File: rtl/blink_slot_counter.sv
module blink_slot_counter
    import led_blink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    output logic [SLOT_W-1:0] slot_nxt_o,
    output logic              wrap_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot_q;

    always_comb begin
        slot_nxt_o = slot_q;
        if (tick_i) begin
            slot_nxt_o = slot_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_nxt_o;
        end
    end

    assign wrap_o = tick_i && (slot_q == LAST_SLOT);

    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(slot_q));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (slot_q == $past(slot_q) + 1'b1));

endmodule

// File: rtl/blink_pattern_fsm.sv
module blink_pattern_fsm
    import led_blink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wrap_i,
    input  logic [SLOT_W-1:0] slot_nxt_i,
    input  logic              rst_active_i,
    input  logic              boot_chg_i,
    input  logic              bank_chg_i,
    output logic              led_o
);
    pat_e             pat_q, pat_d;
    logic [LIT_W-1:0] lit_n;
    logic             led_q, led_d;

    // Next state: HOLD, or FRAME_WRAP with a priority re-selection.
    always_comb begin
        pat_d = pat_q;
        if (wrap_i) begin
            if (rst_active_i) begin
                pat_d = PAT_ALL;
            end else if (boot_chg_i && bank_chg_i) begin
                pat_d = PAT_BOTH;
            end else if (boot_chg_i) begin
                pat_d = PAT_BOOT;
            end else if (bank_chg_i) begin
                pat_d = PAT_BANK;
            end else begin
                pat_d = PAT_OFF;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= PAT_OFF;
        end else begin
            pat_q <= pat_d;
        end
    end

    // Output logic: the lit slots come first in the frame.
    always_comb begin
        lit_n = lit_slots(pat_d);
        led_d = led_q;
        if (tick_i) begin
            led_d = ({1'b0, slot_nxt_i} < lit_n);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q <= 1'b0;
        end else begin
            led_q <= led_d;
        end
    end

    assign led_o = led_q;

    // R9
    pat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap_i |=> $stable(pat_q));

    // R10
    led_slot_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(led_q));

    // R7
    off_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (pat_q == PAT_OFF) |-> !led_q);

    // R3
    all_lit_chk: assert property (@(posedge clk) disable iff (rst)
        (pat_q == PAT_ALL) |-> led_q);

endmodule

// File: rtl/led_frame_blinker.sv
module led_frame_blinker
    import led_blink_pkg::*;
#(
    parameter int PRESCALE_W = 21
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_active_i,
    input  logic boot_chg_i,
    input  logic bank_chg_i,
    output logic led_o
);
    logic              tick;
    logic              wrap;
    logic [SLOT_W-1:0] slot_nxt;

    blink_prescaler #(.PRESCALE_W(PRESCALE_W)) prescale_i (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    blink_slot_counter slot_i (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .slot_nxt_o (slot_nxt),
        .wrap_o     (wrap)
    );

    blink_pattern_fsm fsm_i (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .wrap_i       (wrap),
        .slot_nxt_i   (slot_nxt),
        .rst_active_i (rst_active_i),
        .boot_chg_i   (boot_chg_i),
        .bank_chg_i   (bank_chg_i),
        .led_o        (led_o)
    );

    // R1
    reset_dark_chk: assert property (@(posedge clk)
        rst |=> !led_o);

endmodule

// File: tb/led_frame_blinker_tb.sv
module led_frame_blinker_tb_top;

    localparam int PW    = 3;
    localparam int SLOTC = 1 << PW;
    localparam int FRAME = 8 * SLOTC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_active = 1'b0;
    logic boot_chg = 1'b0;
    logic bank_chg = 1'b0;
    logic led;

    int checks   = 0;
    int failures = 0;
    int ecount   = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ecount <= 0;
        else     ecount <= ecount + 1;
    end

    led_frame_blinker #(.PRESCALE_W(PW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .rst_active_i (rst_active),
        .boot_chg_i   (boot_chg),
        .bank_chg_i   (bank_chg),
        .led_o        (led)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at edge %0d: led=%b expected %b", req, ecount, act, exp);
        end
    endtask

    task automatic set_flags(input logic r, input logic b, input logic v);
        rst_active = r;
        boot_chg   = b;
        bank_chg   = v;
    endtask

    // Advance to the next frame boundary, then check every cycle of that frame.
    task automatic check_frame(input logic r, input logic b, input logic v,
                               input int lit, input string req);
        @(negedge clk);
        set_flags(r, b, v);
        do @(negedge clk); while (ecount % FRAME != 0);
        for (int i = 0; i < FRAME; i++) begin
            chk(led, ((i / SLOTC) < lit), req);
            @(negedge clk);
        end
    endtask

    // R1 / R9: reset state, and the first frame after reset is dark.
    task automatic test_reset_first_frame();
        @(negedge clk);
        set_flags(1'b1, 1'b1, 1'b1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(led, 1'b0, "R1 reset state");
        rst = 1'b0;
        for (int i = 0; i < FRAME; i++) begin
            chk(led, 1'b0, "R9 first frame dark");
            @(negedge clk);
        end
    endtask

    // R9: mid-frame flag change does not truncate the running frame.
    task automatic test_no_truncate();
        @(negedge clk);
        set_flags(1'b0, 1'b1, 1'b0);
        do @(negedge clk); while (ecount % FRAME != 0);
        for (int i = 0; i < FRAME; i++) begin
            chk(led, ((i / SLOTC) < 4), "R9 mid-frame change ignored");
            if (i == 2 * SLOTC + 4) set_flags(1'b1, 1'b0, 1'b0);
            @(negedge clk);
        end
        for (int i = 0; i < FRAME; i++) begin
            chk(led, 1'b1, "R9 change applied at next frame");
            @(negedge clk);
        end
    endtask

    // R1: synchronous reset in mid-frame darkens the LED at once.
    task automatic test_mid_reset();
        @(negedge clk);
        set_flags(1'b1, 1'b0, 1'b0);
        do @(negedge clk); while (ecount % FRAME != 3 * SLOTC + 2);
        chk(led, 1'b1, "R3 lit before reset");
        rst = 1'b1;
        @(negedge clk);
        chk(led, 1'b0, "R1 mid-frame reset clears led");
        rst = 1'b0;
        for (int i = 0; i < FRAME; i++) begin
            chk(led, 1'b0, "R1 restart from slot 0 dark");
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        test_reset_first_frame();
        check_frame(1'b1, 1'b0, 1'b0, 8, "R3 reset-active all lit");
        check_frame(1'b0, 1'b1, 1'b1, 5, "R4 both changed 5 lit");
        check_frame(1'b0, 1'b1, 1'b0, 4, "R5 boot only 4 lit");
        check_frame(1'b0, 1'b0, 1'b1, 3, "R6 bank only 3 lit R2 R10 slot edges");
        check_frame(1'b0, 1'b0, 1'b0, 0, "R7 nothing changed off");
        check_frame(1'b1, 1'b1, 1'b1, 8, "R8 reset-active over both");
        check_frame(1'b1, 1'b1, 1'b0, 8, "R8 reset-active over boot");
        check_frame(1'b1, 1'b0, 1'b1, 8, "R8 reset-active over bank");
        check_frame(1'b0, 1'b1, 1'b1, 5, "R8 both over single");
        test_no_truncate();
        test_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule